// File: doc/BRIEF.md
# Serial Converter Control-Byte Front End

This block is the device side of a four-wire serial link on an 8-bit multi-channel sampling converter. It runs on a synchronous system clock. It synchronises the serial clock, chip select and data input, then finds edges on them. While chip select is low it waits for a start bit on the data input and assembles an 8-bit control word. From that word it decodes the input selection, the polarity, the input mode and the power fields.

The block opens a track window and then a hold window. At the moment of hold it gives a one-cycle request to a separate conversion engine. It then frames the result on the serial output: first a strobe pulse, then one engine bit decision per falling serial-clock edge, most significant bit first. Zeros follow the result.

A new control word may overlap the result of the previous conversion, which gives one conversion every ten serial clocks. Output drivers are not built in. Each output comes with an enable signal instead.

Top module: `adc_serial_front`

## Requirements
- R1: The data input is sampled on rising serial-clock edges while chip select is low. Zeros before the first 1 are discarded, and that first 1 becomes bit 7 of the control word.
- R2: The control word is decoded from bit 7 (start) down to bit 0 as follows. Bits 6..4 are selector s2, s1, s0. Bit 3 is unipolar (1) or bipolar (0). Bit 2 is single-ended (1) or differential (0). Bit 1 is power-on. Bit 0 is external-clock mode. The positive channel is {s1,s0,s2}. The negative channel is the positive channel with bit 0 inverted in differential mode, or 0 with `neg_com`=1 in single-ended mode. All decoded outputs are latched when the word completes.
- R3: `track` is high from the falling edge after the 6th control bit to the falling edge after the 8th. At that 8th-bit falling edge, `conv_start` pulses for exactly one system cycle, once per control word.
- R4: `strb` is high for the two falling edges after the 8th-bit edge. The next 8 falling edges then present the engine's decisions, index 7 down to 0, on `sdo`. `sdo` is 0 at all other falling edges.
- R5: `hold` is high from the 8th-bit falling edge up to the falling edge that presents index 0, and low from that edge on.
- R6: While chip select is high, `sdo_oe` and `strb_oe` are low and serial-clock and data activity is ignored. After chip select falls, `strb` is driven low.
- R7: A 1 on the data input during a conversion is ignored until the most significant result bit has been presented. After that it starts a new control word, so conversions can be placed every 10 serial clocks.
- R8: If chip select goes high and then low before the most significant bit has been presented, the next start bit pulses `conv_abort` for one cycle. It also discards the remaining result bits and begins a new control word.
- R9: After reset, with chip select high, both output enables, `track`, `hold` and `strb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data input |
| dec_bit | input | 1 | Engine bit decision for `dec_idx` |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo` |
| strb | output | 1 | Strobe output |
| strb_oe | output | 1 | Output enable for `strb` |
| track | output | 1 | Track window |
| hold | output | 1 | Hold window, conversion in progress |
| conv_start | output | 1 | One-cycle sample request to the engine |
| conv_abort | output | 1 | One-cycle abort of the running conversion |
| dec_req | output | 1 | Engine decision consumed this cycle |
| dec_idx | output | 3 | Index of the decision being presented |
| mux_pos | output | 3 | Positive input channel code |
| mux_neg | output | 3 | Negative input channel code |
| neg_com | output | 1 | Negative input is the common return |
| unipolar | output | 1 | Unipolar conversion selected |
| pwr_on | output | 1 | Fully operational selected |
| ext_clk | output | 1 | External clock mode selected |

## Verification
The engine model returns a word built from the decoded selection outputs. The result stream therefore exposes framing errors and decode errors at the same time.

Four patterns are used:
- A word preceded by three zeros shows whether the start-bit hunt frames on the first 1.
- Two words placed ten clocks apart, with 1s inserted just before the first result bit, separate early start acceptance from correct overlap.
- A word interrupted by a chip-select pulse during the strobe, then followed by a fresh word, shows whether stale result bits are discarded.
- Serial clocking with chip select high shows that nothing is captured.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;

  localparam int CTRL_W   = 8;
  localparam int CH_W     = 3;
  localparam int TRACK_AT = CTRL_W - 2;

  // control word without its start bit, bit 6 down to bit 0
  typedef struct packed {
    logic [CH_W-1:0] sel;
    logic            unipolar;
    logic            single;
    logic            pwr_on;
    logic            ext_clk;
  } ctrl_t;

  typedef struct packed {
    logic [CH_W-1:0] pos;
    logic [CH_W-1:0] neg;
    logic            neg_com;
  } mux_t;

  function automatic mux_t decode_mux(ctrl_t c);
    mux_t m;
    m.pos     = {c.sel[1], c.sel[0], c.sel[2]};
    m.neg     = c.single ? '0 : (m.pos ^ CH_W'(1));
    m.neg_com = c.single;
    return m;
  endfunction

endpackage

// File: rtl/adcfe_sync.sv
module adcfe_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/adcfe_edge.sv
module adcfe_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/adcfe_rx.sv
module adcfe_rx
  import adcfe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_hi,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  sdi,
  input  logic  hunt_ok,
  output logic  start_acc,
  output logic  byte_fire,
  output logic  track,
  output logic  sample,
  output ctrl_t ctrl_q
);

  localparam int CNT_W = $clog2(CTRL_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] CNT_TRK  = CNT_W'(TRACK_AT);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CTRL_W-2:0] sh_q, sh_d;
  logic              trk_q, trk_d;
  logic              smp_q, smp_d;
  ctrl_t             ctl_d;

  assign start_acc = ~cs_hi & sck_rise & (cnt_q == '0) & sdi & hunt_ok;
  assign byte_fire = ~cs_hi & sck_fall & (cnt_q == CNT_FULL);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    trk_d = trk_q;
    smp_d = 1'b0;
    ctl_d = ctrl_q;
    if (cs_hi) begin
      cnt_d = '0;
      trk_d = 1'b0;
    end else begin
      if (start_acc) begin
        sh_d  = {{(CTRL_W-2){1'b0}}, 1'b1};
        cnt_d = CNT_W'(1);
      end else if (sck_rise && cnt_q != '0 && cnt_q < CNT_FULL) begin
        sh_d  = {sh_q[CTRL_W-3:0], sdi};
        cnt_d = cnt_q + 1'b1;
      end
      if (sck_fall && cnt_q == CNT_TRK) trk_d = 1'b1;
      if (byte_fire) begin
        trk_d = 1'b0;
        cnt_d = '0;
        smp_d = 1'b1;
        ctl_d = ctrl_t'(sh_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      trk_q  <= 1'b0;
      smp_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      trk_q  <= trk_d;
      smp_q  <= smp_d;
      ctrl_q <= ctl_d;
    end
  end

  assign track  = trk_q;
  assign sample = smp_q;

endmodule

// File: rtl/adcfe_tx.sv
module adcfe_tx #(
  parameter int DATA_W    = 8,
  parameter int STRB_CLKS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sck_fall,
  input  logic                      cs_rise,
  input  logic                      cs_fall,
  input  logic                      byte_fire,
  input  logic                      start_acc,
  input  logic                      dec_bit,
  output logic                      sdo,
  output logic                      strb,
  output logic                      busy,
  output logic                      hunt_ok,
  output logic                      abort,
  output logic                      dec_req,
  output logic [$clog2(DATA_W)-1:0] dec_idx
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int PH_W  = $clog2(STRB_CLKS + DATA_W + 1);
  localparam logic [PH_W-1:0] PH_STRB = PH_W'(STRB_CLKS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STRB_CLKS + DATA_W - 1);

  logic            act_q, act_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            msb_q, msb_d;
  logic            bnc_q, bnc_d;
  logic            sdo_q, sdo_d;
  logic            stb_q, stb_d;
  logic            abt_q, abt_d;
  logic            kill;

  assign hunt_ok = ~act_q | msb_q | bnc_q;
  assign kill    = start_acc & act_q & ~msb_q;
  assign dec_req = sck_fall & act_q & ~byte_fire & (ph_q >= PH_STRB);
  assign dec_idx = IDX_W'(PH_LAST - ph_q);

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    msb_d = msb_q;
    bnc_d = bnc_q;
    sdo_d = sdo_q;
    stb_d = stb_q;
    abt_d = kill;
    if (cs_rise && act_q && !msb_q) bnc_d = 1'b1;
    if (cs_fall) stb_d = 1'b0;
    if (kill) begin
      act_d = 1'b0;
      msb_d = 1'b0;
      bnc_d = 1'b0;
      sdo_d = 1'b0;
      stb_d = 1'b0;
    end
    if (sck_fall) begin
      if (byte_fire) begin
        act_d = 1'b1;
        ph_d  = PH_W'(1);
        msb_d = 1'b0;
        bnc_d = 1'b0;
        sdo_d = 1'b0;
        stb_d = 1'b1;
      end else if (act_q) begin
        ph_d = ph_q + 1'b1;
        if (ph_q >= PH_STRB) begin
          stb_d = 1'b0;
          sdo_d = dec_bit;
          msb_d = 1'b1;
          if (dec_idx == '0) begin
            act_d = 1'b0;
            msb_d = 1'b0;
            bnc_d = 1'b0;
          end
        end
      end else begin
        sdo_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      msb_q <= 1'b0;
      bnc_q <= 1'b0;
      sdo_q <= 1'b0;
      stb_q <= 1'b0;
      abt_q <= 1'b0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      msb_q <= msb_d;
      bnc_q <= bnc_d;
      sdo_q <= sdo_d;
      stb_q <= stb_d;
      abt_q <= abt_d;
    end
  end

  assign sdo   = sdo_q;
  assign strb  = stb_q;
  assign busy  = act_q;
  assign abort = abt_q;

endmodule

// File: rtl/adc_serial_front.sv
module adc_serial_front
  import adcfe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STRB_CLKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic                      sdi,
  input  logic                      dec_bit,
  output logic                      sdo,
  output logic                      sdo_oe,
  output logic                      strb,
  output logic                      strb_oe,
  output logic                      track,
  output logic                      hold,
  output logic                      conv_start,
  output logic                      conv_abort,
  output logic                      dec_req,
  output logic [$clog2(DATA_W)-1:0] dec_idx,
  output logic [CH_W-1:0]           mux_pos,
  output logic [CH_W-1:0]           mux_neg,
  output logic                      neg_com,
  output logic                      unipolar,
  output logic                      pwr_on,
  output logic                      ext_clk
);

  logic [2:0] pin_s;
  logic [1:0] rise, fall;
  logic       cs_hi, sck_rise, sck_fall;
  logic       start_acc, byte_fire, hunt_ok;
  ctrl_t      ctrl_q;
  mux_t       mux;

  // bit 0 chip select, bit 1 serial clock, bit 2 data in
  adcfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdi, sclk, cs_n}), .dout(pin_s)
  );

  adcfe_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pin_s[1:0]), .rise(rise), .fall(fall)
  );

  assign cs_hi    = pin_s[0];
  assign sck_rise = rise[1] & ~cs_hi;
  assign sck_fall = fall[1] & ~cs_hi;

  adcfe_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .sdi(pin_s[2]), .hunt_ok(hunt_ok),
    .start_acc(start_acc), .byte_fire(byte_fire), .track(track),
    .sample(conv_start), .ctrl_q(ctrl_q)
  );

  adcfe_tx #(.DATA_W(DATA_W), .STRB_CLKS(STRB_CLKS)) u_tx (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .cs_rise(rise[0]),
    .cs_fall(fall[0]), .byte_fire(byte_fire), .start_acc(start_acc),
    .dec_bit(dec_bit), .sdo(sdo), .strb(strb), .busy(hold),
    .hunt_ok(hunt_ok), .abort(conv_abort), .dec_req(dec_req),
    .dec_idx(dec_idx)
  );

  assign mux      = decode_mux(ctrl_q);
  assign mux_pos  = mux.pos;
  assign mux_neg  = mux.neg;
  assign neg_com  = mux.neg_com;
  assign unipolar = ctrl_q.unipolar;
  assign pwr_on   = ctrl_q.pwr_on;
  assign ext_clk  = ctrl_q.ext_clk;
  assign sdo_oe   = ~cs_hi;
  assign strb_oe  = ~cs_hi;

endmodule

// File: rtl/adc_serial_front_chk.sv
module adc_serial_front_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic conv_abort,
  input logic hold,
  input logic track,
  input logic strb,
  input logic dec_req
);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_track_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !track);

  assert_hold_with_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> conv_start);

  assert_strobe_with_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb) |-> conv_start);

  assert_strobe_off_after_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_req |=> !strb);

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> !hold);

  assert_abort_vs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, conv_abort}));

endmodule

bind adc_serial_front adc_serial_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_abort(conv_abort),
  .hold(hold), .track(track), .strb(strb), .dec_req(dec_req)
);

// File: tb/adc_serial_front_tb.sv
module adc_serial_front_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk, rst_n, cs_n, sclk, sdi, dec_bit;
  logic       sdo, sdo_oe, strb, strb_oe, track, hold;
  logic       conv_start, conv_abort, dec_req;
  logic [2:0] dec_idx, mux_pos, mux_neg;
  logic       neg_com, unipolar, pwr_on, ext_clk;
  logic [7:0] eng_word;

  adc_serial_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .dec_bit(dec_bit), .sdo(sdo), .sdo_oe(sdo_oe), .strb(strb),
    .strb_oe(strb_oe), .track(track), .hold(hold), .conv_start(conv_start),
    .conv_abort(conv_abort), .dec_req(dec_req), .dec_idx(dec_idx),
    .mux_pos(mux_pos), .mux_neg(mux_neg), .neg_com(neg_com),
    .unipolar(unipolar), .pwr_on(pwr_on), .ext_clk(ext_clk)
  );

  // conversion engine model: decisions form a word from the decoded selection
  assign eng_word = {unipolar, neg_com, mux_pos, mux_neg};
  assign dec_bit  = eng_word[dec_idx];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, n_start = 0, n_abort = 0;

  always @(posedge clk) begin
    if (rst_n && conv_start) n_start++;
    if (rst_n && conv_abort) n_abort++;
  end

  typedef struct packed {
    logic       sdo;
    logic       strb;
    logic       trk;
    logic       hld;
    logic [7:0] idx;
  } exp_t;

  exp_t  exp_q[$];
  event  smp_ev;
  logic [63:0] din_a, e_sdo, e_strb, e_trk, e_hold;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(smp_ev);
      e = exp_q.pop_front();
      chk(sdo === e.sdo,   $sformatf("R4 sdo clock %0d", e.idx), int'(sdo), int'(e.sdo));
      chk(strb === e.strb, $sformatf("R4 strobe clock %0d", e.idx), int'(strb), int'(e.strb));
      chk(track === e.trk, $sformatf("R3 track clock %0d", e.idx), int'(track), int'(e.trk));
      chk(hold === e.hld,  $sformatf("R5 hold clock %0d", e.idx), int'(hold), int'(e.hld));
    end
  end

  function automatic logic [7:0] exp_res(input logic [7:0] b);
    logic [2:0] pos, neg;
    pos = {b[5], b[4], b[6]};
    neg = b[2] ? 3'd0 : (pos ^ 3'd1);
    return {b[3], b[2], pos, neg};
  endfunction

  task automatic clear_plan();
    din_a = '0; e_sdo = '0; e_strb = '0; e_trk = '0; e_hold = '0;
  endtask

  task automatic plan_conv(input int s, input logic [7:0] b);
    int k;
    logic [7:0] r;
    k = s + 7;
    r = exp_res(b);
    for (int i = 0; i < 8; i++) din_a[s+i] = b[7-i];
    e_trk[s+5] = 1'b1;
    e_trk[s+6] = 1'b1;
    for (int j = k; j <= k + 8; j++) e_hold[j] = 1'b1;
    e_strb[k]   = 1'b1;
    e_strb[k+1] = 1'b1;
    for (int i = 0; i < 8; i++) e_sdo[k+2+i] = r[7-i];
  endtask

  task automatic clk_bit(input logic d);
    sdi = d;
    repeat (2) @(posedge clk);
    sclk = 1'b1;
    repeat (HALF) @(posedge clk);
    sclk = 1'b0;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 1; i <= n; i++) begin
      exp_q.push_back('{e_sdo[i], e_strb[i], e_trk[i], e_hold[i], 8'(i)});
      clk_bit(din_a[i]);
      ->smp_ev;
      #1;
    end
  endtask

  task automatic cs_set(input logic v);
    cs_n = v;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    clear_plan();
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R9 reset state
    chk(sdo_oe == 1'b0, "R9 sdo_oe", int'(sdo_oe), 0);
    chk(strb_oe == 1'b0, "R9 strb_oe", int'(strb_oe), 0);
    chk(track == 1'b0 && hold == 1'b0, "R9 track/hold", int'({track, hold}), 0);
    chk(strb == 1'b0, "R9 strobe", int'(strb), 0);

    // R6: clocking ones with chip select high is ignored
    for (int i = 0; i < 10; i++) clk_bit(1'b1);
    chk(n_start == 0, "R6 no start while deselected", n_start, 0);
    chk(track == 1'b0, "R6 no track while deselected", int'(track), 0);
    chk(sdo_oe == 1'b0, "R6 sdo_oe high-z", int'(sdo_oe), 0);
    cs_set(1'b0);
    chk(sdo_oe == 1'b1 && strb_oe == 1'b1, "R6 enables after select", int'({sdo_oe, strb_oe}), 3);
    chk(strb == 1'b0, "R6 strobe low after select", int'(strb), 0);

    // R1 R2 R3 R4 R5: three leading zeros, single-ended unipolar? no, bipolar single-ended
    clear_plan();
    plan_conv(4, 8'hA7);
    run(24);
    chk(n_start == 1, "R3 one start per word", n_start, 1);
    chk(mux_pos == 3'd4 && neg_com == 1'b1 && mux_neg == 3'd0, "R2 single-ended decode",
        int'({mux_pos, neg_com, mux_neg}), int'({3'd4, 1'b1, 3'd0}));
    chk(pwr_on == 1'b1 && ext_clk == 1'b1 && unipolar == 1'b0, "R2 mode fields",
        int'({pwr_on, ext_clk, unipolar}), 6);

    cs_set(1'b1);
    cs_set(1'b0);

    // R7: back-to-back words ten clocks apart, early ones ignored
    clear_plan();
    plan_conv(1, 8'hDB);
    din_a[9]  = 1'b1;
    din_a[10] = 1'b1;
    plan_conv(11, 8'hB2);
    run(30);
    chk(n_start == 3, "R7 two overlapped conversions", n_start, 3);
    chk(n_abort == 0, "R8 no abort without chip-select toggle", n_abort, 0);
    chk(mux_pos == 3'd6 && mux_neg == 3'd7 && neg_com == 1'b0, "R2 differential decode",
        int'({mux_pos, mux_neg, neg_com}), int'({3'd6, 3'd7, 1'b0}));
    chk(pwr_on == 1'b1 && ext_clk == 1'b0 && unipolar == 1'b0, "R2 second word fields",
        int'({pwr_on, ext_clk, unipolar}), 4);

    cs_set(1'b1);
    cs_set(1'b0);

    // R8: chip select pulse during the strobe, then a fresh word aborts
    clear_plan();
    plan_conv(1, 8'hFF);
    run(9);
    cs_set(1'b1);
    chk(sdo_oe == 1'b0 && strb_oe == 1'b0, "R6 high-z during pulse", int'({sdo_oe, strb_oe}), 0);
    cs_set(1'b0);
    chk(strb == 1'b0 && strb_oe == 1'b1, "R6 strobe driven low", int'({strb, strb_oe}), 1);
    clear_plan();
    plan_conv(1, 8'hEF);
    run(20);
    chk(n_abort == 1, "R8 abort pulse", n_abort, 1);
    chk(n_start == 5, "R8 new conversion started", n_start, 5);
    chk(mux_pos == 3'd5 && neg_com == 1'b1 && unipolar == 1'b1, "R2 decode after abort",
        int'({mux_pos, neg_com, unipolar}), int'({3'd5, 1'b1, 1'b1}));

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule